// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block turns a bank of filtered pin levels into pending interrupt bits and a single bank interrupt line. By default a pin reports any change of level, rising or falling. Each pin can be switched to an additional mode where it reports only one kind of event. That event is a rising edge, a falling edge, a high level or a low level, selected by a type bit and a polarity bit.

Configuration arrives as write-one commands on a command port. Each command carries an operation code and a bit vector. Only the pins whose data bit is 1 are touched. The configuration registers and the pending status are visible at all times on output ports.

A one-cycle status-read strobe tells the block that software has taken the status. The strobe acknowledges every pending edge bit. Level bits keep following their pin condition. The bank line is high while any pending pin is also enabled in the mask.

Top module: `pin_chg_irq`

## Requirements
- R1: After reset the mask, mode, type and polarity outputs are all zero, which means masked, additional modes off, edge type and falling/low polarity. The status output and `bank_irq` are also zero.
- R2: `cmd_op` 1 sets, and `cmd_op` 0 clears, the mask bits where `cmd_data` is 1. Other mask bits keep their value. `mask_q` shows the change after the next clock edge.
- R3: `cmd_op` 3 turns on, and `cmd_op` 2 turns off, the additional mode for the pins selected by `cmd_data`. The result is read back on `mode_q`.
- R4: `cmd_op` 5 selects level type and `cmd_op` 4 selects edge type (`level_q` bit 1 means level). `cmd_op` 7 selects rising/high polarity and `cmd_op` 6 selects falling/low polarity (`pol_q` bit 1 means rising/high). All of these are write-one per pin.
- R5: With the additional mode off, every rising or falling change of a pin sets that pin's status bit. The bit is visible one clock edge after the changed level is sampled.
- R6: With the additional mode on and edge type selected, only the edge matching `pol_q` sets the pin's status bit.
- R7: With the additional mode on and level type selected, the pin's status bit follows the condition "pin equals `pol_q`", one cycle late. A status read does not clear it while the condition holds.
- R8: A cycle with `stat_rd` high clears every pending edge bit at the next edge. An edge event sampled at that same edge stays pending.
- R9: `bank_irq` is high exactly when some status bit is set on a pin whose mask bit is 1. Pending bits are recorded regardless of the mask.
- R10: A command with `cmd_valid` low, or with `cmd_op` from 8 to 15, changes no register.
- R11: The first pin sample after reset release is taken as the reference level and raises no edge event, even when pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Filtered pin levels |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_data | input | NPINS | Per-pin select vector for the command |
| stat_rd | input | 1 | Status-read strobe, acknowledges edge events |
| stat_q | output | NPINS | Pending status per pin |
| mask_q | output | NPINS | Interrupt enables |
| mode_q | output | NPINS | Additional-mode enables |
| level_q | output | NPINS | Type per pin, 0 edge / 1 level |
| pol_q | output | NPINS | Polarity per pin, 1 rising/high |
| bank_irq | output | 1 | Bank interrupt line |

## Verification
The checker watches the command effects on every cycle. It confirms that set and clear ops reach the mask and that polarity writes reach `pol_q`. It confirms that any pin change in default mode lands in the status. It confirms that a held level condition is pending the next cycle. It confirms that a status read with quiet pins empties the status. It confirms that the bank line never rises with an empty mask.

Only the directed scenarios can show three things that depend on a chosen history. The first is that the opposite edge is ignored in single-edge mode. The second is that an edge is kept when it coincides with a read. The third is that no event follows reset with pins high, and that ignored opcodes leave every register alone.

// File: rtl/pcirq_pkg.sv
`timescale 1ns/1ps
package pcirq_pkg;
  // Opcode layout: bit 3 must be zero, bits 2:1 pick the field, bit 0 is the value written.
  localparam int unsigned OP_W    = 4;
  localparam int unsigned NFIELDS = 4;

  typedef enum logic [1:0] {
    FLD_MASK  = 2'd0,
    FLD_MODE  = 2'd1,
    FLD_TYPE  = 2'd2,
    FLD_POL   = 2'd3
  } field_e;

  function automatic logic op_hits(input logic [OP_W-1:0] op, input int unsigned fld,
                                   input logic val);
    return (op[3] == 1'b0) && (op[2:1] == fld[1:0]) && (op[0] == val);
  endfunction
endpackage

// File: rtl/pcirq_setclr.sv
`timescale 1ns/1ps
module pcirq_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] sel,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;
  logic         upd;

  always_comb begin
    upd = set_en | clr_en;
    q_d = q_r;
    if (set_en)      q_d = q_r | sel;
    else if (clr_en) q_d = q_r & ~sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/pcirq_cfg.sv
`timescale 1ns/1ps
module pcirq_cfg
  import pcirq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [NPINS-1:0] cmd_data,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] mode_q,
  output logic [NPINS-1:0] level_q,
  output logic [NPINS-1:0] pol_q
);
  logic [NPINS-1:0] fld_q [NFIELDS];

  for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
    logic set_en, clr_en;
    always_comb begin
      set_en = cmd_valid && op_hits(cmd_op, f, 1'b1);
      clr_en = cmd_valid && op_hits(cmd_op, f, 1'b0);
    end
    pcirq_setclr #(.W(NPINS)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_en),
      .clr_en (clr_en),
      .sel    (cmd_data),
      .q      (fld_q[f])
    );
  end

  assign mask_q  = fld_q[FLD_MASK];
  assign mode_q  = fld_q[FLD_MODE];
  assign level_q = fld_q[FLD_TYPE];
  assign pol_q   = fld_q[FLD_POL];
endmodule

// File: rtl/pcirq_detect.sv
`timescale 1ns/1ps
module pcirq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] level_q,
  input  logic [NPINS-1:0] pol_q,
  output logic [NPINS-1:0] edge_evt,
  output logic [NPINS-1:0] lvl_hit
);
  logic [NPINS-1:0] prev_q;
  logic             armed_q;
  logic [NPINS-1:0] rise, fall, pick;

  always_comb begin
    rise = pin_lvl & ~prev_q;
    fall = ~pin_lvl & prev_q;
    for (int i = 0; i < NPINS; i++) begin
      if (!mode_q[i])     pick[i] = rise[i] | fall[i];
      else if (level_q[i]) pick[i] = 1'b0;
      else                 pick[i] = pol_q[i] ? rise[i] : fall[i];
    end
    edge_evt = armed_q ? pick : '0;
    lvl_hit  = mode_q & level_q & ~(pin_lvl ^ pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= pin_lvl;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pcirq_pend.sv
`timescale 1ns/1ps
module pcirq_pend #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] edge_evt,
  input  logic [NPINS-1:0] lvl_hit,
  input  logic             stat_rd,
  output logic [NPINS-1:0] stat_q
);
  logic [NPINS-1:0] edge_q, edge_d, lvl_q;

  always_comb begin
    edge_d = (stat_rd ? '0 : edge_q) | edge_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      lvl_q  <= '0;
    end else begin
      edge_q <= edge_d;
      lvl_q  <= lvl_hit;
    end
  end

  assign stat_q = edge_q | lvl_q;
endmodule

// File: rtl/pin_chg_irq.sv
`timescale 1ns/1ps
module pin_chg_irq
  import pcirq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [NPINS-1:0] cmd_data,
  input  logic             stat_rd,
  output logic [NPINS-1:0] stat_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] mode_q,
  output logic [NPINS-1:0] level_q,
  output logic [NPINS-1:0] pol_q,
  output logic             bank_irq
);
  logic [NPINS-1:0] edge_evt, lvl_hit;

  pcirq_cfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mask_q(mask_q), .mode_q(mode_q),
    .level_q(level_q), .pol_q(pol_q)
  );

  pcirq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .mode_q(mode_q),
    .level_q(level_q), .pol_q(pol_q), .edge_evt(edge_evt), .lvl_hit(lvl_hit)
  );

  pcirq_pend #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .lvl_hit(lvl_hit),
    .stat_rd(stat_rd), .stat_q(stat_q)
  );

  assign bank_irq = |(stat_q & mask_q);
endmodule

// File: rtl/pcirq_chk.sv
`timescale 1ns/1ps
module pcirq_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_lvl,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [NPINS-1:0] cmd_data,
  input logic             stat_rd,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] mode_q,
  input logic [NPINS-1:0] level_q,
  input logic [NPINS-1:0] pol_q,
  input logic             bank_irq
);
  logic [1:0]       warm_q;
  logic [NPINS-1:0] lvl_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= 2'd0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  assign lvl_cond = mode_q & level_q & ~(pin_lvl ^ pol_q);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd1) |=> ((mask_q & $past(cmd_data)) == $past(cmd_data)));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd0) |=> ((mask_q & $past(cmd_data)) == '0));

  // R4
  pol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd7) |=> ((pol_q & $past(cmd_data)) == $past(cmd_data)));

  // R5
  any_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && mode_q == '0 && pin_lvl != $past(pin_lvl))
    |=> ((stat_q & ($past(pin_lvl) ^ $past(pin_lvl, 2))) == ($past(pin_lvl) ^ $past(pin_lvl, 2))));

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_cond != '0) |=> ((stat_q & $past(lvl_cond)) == $past(lvl_cond)));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && mode_q == '0 && $stable(pin_lvl)) |=> (stat_q == '0));

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> ($countones(mask_q) > 0));
endmodule

bind pin_chg_irq pcirq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .stat_rd(stat_rd), .stat_q(stat_q),
  .mask_q(mask_q), .mode_q(mode_q), .level_q(level_q), .pol_q(pol_q),
  .bank_irq(bank_irq)
);

// File: tb/tb_pin_chg_irq.sv
`timescale 1ns/1ps
module tb_pin_chg_irq;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_lvl;
  logic         cmd_valid;
  logic [3:0]   cmd_op;
  logic [N-1:0] cmd_data;
  logic         stat_rd;
  logic [N-1:0] stat_q, mask_q, mode_q, level_q, pol_q;
  logic         bank_irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pin_chg_irq #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .stat_rd(stat_rd), .stat_q(stat_q),
    .mask_q(mask_q), .mode_q(mode_q), .level_q(level_q), .pol_q(pol_q),
    .bank_irq(bank_irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cmd(input logic v, input logic [3:0] op, input logic [N-1:0] d);
    cmd_valid = v; cmd_op = op; cmd_data = d;
    cyc();
    cmd_valid = 1'b0; cmd_data = '0; cmd_op = 4'd0;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    pin_lvl = v;
    cyc();
  endtask

  task automatic read_stat();
    stat_rd = 1'b1;
    cyc();
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mask", mask_q, '0);
    chk("R1 mode", mode_q, '0);
    chk("R1 type", level_q, '0);
    chk("R1 pol", pol_q, '0);
    chk("R1 irq", {31'd0, bank_irq}, '0);
    cyc(); cyc();
    // R11: pins were high through reset release
    chk("R11 no event", stat_q, '0);
  endtask

  task automatic t_mask();
    cmd(1'b1, 4'd1, 32'h0000_00F0);
    chk("R2 set", mask_q, 32'h0000_00F0);
    cmd(1'b1, 4'd1, 32'h0000_0003);
    chk("R2 set keeps", mask_q, 32'h0000_00F3);
    cmd(1'b1, 4'd0, 32'h0000_0010);
    chk("R2 clear", mask_q, 32'h0000_00E3);
    cmd(1'b1, 4'd0, '1);
    chk("R2 clear all", mask_q, '0);
  endtask

  task automatic t_ignored();
    for (int op = 8; op < 16; op++) cmd(1'b1, op[3:0], '1);
    cmd(1'b0, 4'd1, '1);
    cmd(1'b0, 4'd3, '1);
    chk("R10 mask", mask_q, '0);
    chk("R10 mode", mode_q, '0);
    chk("R10 type", level_q, '0);
    chk("R10 pol", pol_q, '0);
  endtask

  task automatic t_default_edges();
    set_pins(pin_lvl & ~32'h1);
    chk("R5 fall", stat_q, 32'h1);
    read_stat();
    chk("R8 cleared", stat_q, '0);
    set_pins(pin_lvl & ~32'h4);
    set_pins(pin_lvl | 32'h4);
    chk("R5 rise", stat_q, 32'h4);
    read_stat();
    chk("R8 cleared again", stat_q, '0);
  endtask

  task automatic t_irq();
    cmd(1'b1, 4'd1, 32'h20);
    set_pins(pin_lvl ^ 32'h10);
    chk("R9 pending unmasked", stat_q, 32'h10);
    chk("R9 irq low", {31'd0, bank_irq}, '0);
    set_pins(pin_lvl ^ 32'h20);
    chk("R9 irq high", {31'd0, bank_irq}, 32'h1);
    read_stat();
    chk("R9 irq after read", {31'd0, bank_irq}, '0);
    cmd(1'b1, 4'd0, '1);
  endtask

  task automatic t_edge_mode();
    cmd(1'b1, 4'd3, 32'h100);
    cmd(1'b1, 4'd7, 32'h100);
    chk("R3 mode rb", mode_q, 32'h100);
    chk("R4 pol rb", pol_q, 32'h100);
    set_pins(pin_lvl & ~32'h100);
    chk("R6 fall ignored", stat_q, '0);
    set_pins(pin_lvl | 32'h100);
    chk("R6 rise seen", stat_q, 32'h100);
    read_stat();
    cmd(1'b1, 4'd6, 32'h100);
    chk("R4 pol cleared", pol_q, '0);
    set_pins(pin_lvl & ~32'h100);
    chk("R6 fall seen", stat_q, 32'h100);
    read_stat();
    cmd(1'b1, 4'd2, 32'h100);
    chk("R3 mode off", mode_q, '0);
  endtask

  task automatic t_level();
    cmd(1'b1, 4'd3, 32'h1000);
    cmd(1'b1, 4'd5, 32'h1000);
    cmd(1'b1, 4'd7, 32'h1000);
    chk("R4 type rb", level_q, 32'h1000);
    cyc();
    chk("R7 level high", stat_q, 32'h1000);
    read_stat();
    chk("R7 held after read", stat_q, 32'h1000);
    set_pins(pin_lvl & ~32'h1000);
    chk("R7 drops", stat_q, '0);
    cmd(1'b1, 4'd6, 32'h1000);
    cyc();
    chk("R7 level low", stat_q, 32'h1000);
    cmd(1'b1, 4'd2, 32'h1000);
    cmd(1'b1, 4'd4, 32'h1000);
    cmd(1'b1, 4'd6, 32'h1000);
    cyc();
    chk("R4 type edge", level_q, '0);
    chk("R7 gone", stat_q, '0);
  endtask

  task automatic t_collide();
    set_pins(pin_lvl ^ 32'h2_0000);
    chk("R8 setup", stat_q, 32'h2_0000);
    pin_lvl = pin_lvl ^ 32'h1_0000;
    read_stat();
    chk("R8 same-cycle edge kept", stat_q, 32'h1_0000);
    read_stat();
    chk("R8 final clear", stat_q, '0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; pin_lvl = '1; cmd_valid = 1'b0; cmd_op = '0;
    cmd_data = '0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_ignored();
    t_default_edges();
    t_irq();
    t_edge_mode();
    t_level();
    t_collide();
    summary();
  end
endmodule